// File: doc/BRIEF.md
# Pointer Masking Control Register File

This block keeps the control state for address pointer masking at four privilege levels: machine, supervisor, virtual supervisor and user. The user level is shared by plain and virtualised user code. Each level has three registers. The control word carries a 3-bit field per level. The mask register selects which effective-address bits are ignored. The base register supplies a value for the bits that are replaced. A mask/base pair belongs to each level. A two-bit context-state field tells a context-switch routine whether the masking registers hold unsaved data.

Software reaches the registers through a simple access port. The port takes a 12-bit register address, write data, a write strobe and the current privilege level. It returns read data and an illegal-access flag in the same cycle. Writes take effect at the next rising clock edge.

Permission rules:
- Lower levels can only reach their own registers and those of levels below them.
- A level may change its own registers only when its self-management bit is set.
- The control word is shown to each level through a restricted view.

All masks, bases, control fields and the state field are exported continuously for the address-masking datapath.

Top module: `pmc_regfile`

## Requirements
- R1: The recognised addresses are 0x3c0/0x3c1/0x3c2 (control, mask, base of the machine level), 0x1c0..0x1c2 (supervisor), 0x2c0..0x2c2 (virtual supervisor) and 0x4c0..0x4c2 (user). Any other address asserts `csr_illegal`, returns zero read data and changes nothing.
- R2: Each level is numbered as follows: user=0, virtual supervisor=1, supervisor=2, machine=3. An access from a `cur_mode` numerically below the register's level asserts `csr_illegal`, reads as zero, and a write there changes no register.
- R3: The machine control view places the fields as follows:
  - bits 11:9: machine control
  - bits 8:6: supervisor control
  - bits 5:3: user control
  - bits 1:0: state field
  - bit 2 and bits above 11: read as zero
- R4: The supervisor and virtual-supervisor views place the fields as follows:
  - bits 8:6: their own control
  - bits 5:3: user control
  - bits 1:0: state field
  The user view exposes only the user control in bits 5:3; the state field neither reads there nor can be written through it.
- R5: Each control field is {apply-to-instructions (bit 2), self-manage (bit 1), enable (bit 0)}. The machine self-manage bit always reads 1, whatever is written.
- R6: A write by a level to its own control, mask or base register is ignored when that level's self-manage bit is 0. A higher level's write always takes effect.
- R7: While the state field is 0 (off), writes to mask, base and control fields are ignored. The state field itself stays writable through a permitted supervisor-or-higher control view.
- R8: Any write that changes the value of a mask, base or control field sets the state field to 3 (dirty) at the same clock edge.
- R9: A control-view write that leaves all control fields unchanged loads the state field from write-data bits 1:0 (1 initial, 2 clean, 3 dirty, 0 off).
- R10: Mask bits below `MASK_LSB` are not implemented: they read as zero and ignore writes. Base registers keep all bits.
- R11: After reset every mask, base and control field is zero, except the machine self-manage bit, and the state field is 1. The machine control view therefore reads 0x401.
- R12: `pm_mask`, `pm_base` and `pm_ctl` (indexed by level) and `pm_state` follow the stored registers, updated at the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_addr | input | 12 | Register address |
| csr_wdata | input | XLEN | Write data |
| csr_we | input | 1 | Write strobe |
| cur_mode | input | 2 | Current privilege level (0 user, 1 virtual supervisor, 2 supervisor, 3 machine) |
| csr_rdata | output | XLEN | Read data for `csr_addr`, combinational |
| csr_illegal | output | 1 | Address unknown or level too low, combinational |
| pm_mask | output | 4 x XLEN | Mask per level |
| pm_base | output | 4 x XLEN | Base per level |
| pm_ctl | output | 4 x 3 | Control field per level |
| pm_state | output | 2 | Context state field |

## Verification
The block's results arrive on two timescales:
- Read data and the illegal flag are combinational, so they are due in the same cycle that address and level are presented.
- Every register update is due after exactly one rising edge. This includes the forced dirty state, which appears at the very edge that commits the changing write.

The driver applies each access at a falling edge. A write holds its strobe for exactly one cycle. The monitor samples 2 ns after that falling edge, so every read check lands in the cycle after the committing edge. Export checks ride on the same item as the read that follows the write, so each result is compared in the cycle where it must first be valid.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    localparam int NLVL = 4;
    localparam int CFGW = 12;

    typedef enum logic [1:0] {
        LV_U  = 2'd0,
        LV_VS = 2'd1,
        LV_S  = 2'd2,
        LV_M  = 2'd3
    } pm_lvl_e;

    typedef enum logic [1:0] {
        RK_CFG  = 2'd0,
        RK_MASK = 2'd1,
        RK_BASE = 2'd2,
        RK_NONE = 2'd3
    } pm_kind_e;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_INIT  = 2'd1,
        ST_CLEAN = 2'd2,
        ST_DIRTY = 2'd3
    } pm_state_e;

    typedef struct packed {
        logic instr;
        logic selfmod;
        logic en;
    } pm_ctl_t;

    typedef struct packed {
        logic     hit;
        pm_lvl_e  lvl;
        pm_kind_e kind;
    } pm_dec_t;

    // Address decode: page nibble picks the level, low byte picks the register.
    function automatic pm_dec_t pm_decode(input logic [11:0] a);
        pm_dec_t d;
        d.hit  = 1'b1;
        d.lvl  = LV_U;
        d.kind = RK_NONE;
        case (a[11:8])
            4'h1:    d.lvl = LV_S;
            4'h2:    d.lvl = LV_VS;
            4'h3:    d.lvl = LV_M;
            4'h4:    d.lvl = LV_U;
            default: d.hit = 1'b0;
        endcase
        case (a[7:0])
            8'hc0:   d.kind = RK_CFG;
            8'hc1:   d.kind = RK_MASK;
            8'hc2:   d.kind = RK_BASE;
            default: d.hit  = 1'b0;
        endcase
        return d;
    endfunction

    // Restricted view of the control word for each level.
    function automatic logic [CFGW-1:0] pm_view(input pm_lvl_e v,
                                                input logic [NLVL-1:0][2:0] c,
                                                input logic [1:0] st);
        logic [CFGW-1:0] r;
        case (v)
            LV_M:    r = {c[LV_M], c[LV_S],  c[LV_U], 1'b0, st};
            LV_S:    r = {3'b000,  c[LV_S],  c[LV_U], 1'b0, st};
            LV_VS:   r = {3'b000,  c[LV_VS], c[LV_U], 1'b0, st};
            default: r = {6'b0,    c[LV_U],  3'b000};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pmc_access.sv
module pmc_access
    import pmc_pkg::*;
(
    input  logic [11:0]     addr,
    input  logic [1:0]      mode,
    input  logic            we,
    input  logic [NLVL-1:0] selfmod,
    output pm_dec_t         dec,
    output logic            illegal,
    output logic            wr_ok
);

    logic own_level;

    always_comb begin
        dec       = pm_decode(addr);
        illegal   = !dec.hit || (mode < dec.lvl);
        own_level = (mode == dec.lvl);
        wr_ok     = we && !illegal && !(own_level && !selfmod[dec.lvl]);
    end

endmodule

// File: rtl/pmc_bank.sv
module pmc_bank #(
    parameter int XLEN     = 64,
    parameter int MASK_LSB = 48
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_mask,
    input  logic            wr_base,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] mask,
    output logic [XLEN-1:0] base,
    output logic            changed
);

    localparam logic [XLEN-1:0] MASK_IMPL = {XLEN{1'b1}} << MASK_LSB;

    logic [XLEN-1:0] mask_new;

    always_comb begin
        mask_new = wdata & MASK_IMPL;
        changed  = (wr_mask && (mask_new != mask)) || (wr_base && (wdata != base));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= '0;
            base <= '0;
        end else begin
            if (wr_mask) mask <= mask_new;
            if (wr_base) base <= wdata;
        end
    end

    assert_mask_impl_R10: assert property (@(posedge clk) disable iff (rst)
        wr_mask |=> ((mask & ~MASK_IMPL) == '0));

endmodule

// File: rtl/pmc_ctl.sv
module pmc_ctl
    import pmc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_wr,
    input  pm_lvl_e               cfg_lvl,
    input  logic [CFGW-1:0]       wdata,
    input  logic                  bank_changed,
    output pm_ctl_t [NLVL-1:0]    ctl,
    output pm_state_e             state
);

    pm_ctl_t [NLVL-1:0] ctl_nxt;
    pm_state_e          st_nxt;
    logic               ctl_changed;
    logic               st_direct;

    always_comb begin
        ctl_nxt = ctl;
        if (cfg_wr && state != ST_OFF) begin
            case (cfg_lvl)
                LV_M: begin
                    ctl_nxt[LV_M] = pm_ctl_t'(wdata[11:9]);
                    ctl_nxt[LV_S] = pm_ctl_t'(wdata[8:6]);
                    ctl_nxt[LV_U] = pm_ctl_t'(wdata[5:3]);
                end
                LV_S: begin
                    ctl_nxt[LV_S] = pm_ctl_t'(wdata[8:6]);
                    ctl_nxt[LV_U] = pm_ctl_t'(wdata[5:3]);
                end
                LV_VS: begin
                    ctl_nxt[LV_VS] = pm_ctl_t'(wdata[8:6]);
                    ctl_nxt[LV_U]  = pm_ctl_t'(wdata[5:3]);
                end
                default: ctl_nxt[LV_U] = pm_ctl_t'(wdata[5:3]);
            endcase
        end
        ctl_nxt[LV_M].selfmod = 1'b1;
        ctl_changed = (ctl_nxt != ctl);
        st_direct   = cfg_wr && (cfg_lvl != LV_U);
        if (ctl_changed || bank_changed) st_nxt = ST_DIRTY;
        else if (st_direct)              st_nxt = pm_state_e'(wdata[1:0]);
        else                             st_nxt = state;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl                <= '0;
            ctl[LV_M].selfmod  <= 1'b1;
            state              <= ST_INIT;
        end else begin
            ctl   <= ctl_nxt;
            state <= st_nxt;
        end
    end

    assert_off_holds_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_OFF && !st_direct) |=> (state == ST_OFF));

    assert_dirty_on_change_R8: assert property (@(posedge clk) disable iff (rst)
        bank_changed |=> (state == ST_DIRTY));

endmodule

// File: rtl/pmc_regfile.sv
module pmc_regfile
    import pmc_pkg::*;
#(
    parameter int XLEN     = 64,
    parameter int MASK_LSB = 48
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [11:0]                csr_addr,
    input  logic [XLEN-1:0]            csr_wdata,
    input  logic                       csr_we,
    input  logic [1:0]                 cur_mode,
    output logic [XLEN-1:0]            csr_rdata,
    output logic                       csr_illegal,
    output logic [NLVL-1:0][XLEN-1:0]  pm_mask,
    output logic [NLVL-1:0][XLEN-1:0]  pm_base,
    output logic [NLVL-1:0][2:0]       pm_ctl,
    output logic [1:0]                 pm_state
);

    pm_dec_t            dec;
    logic               wr_ok;
    logic [NLVL-1:0]    selfmod;
    logic [NLVL-1:0]    bchg;
    logic               bank_changed;
    logic               state_on;
    logic               cfg_wr;
    pm_ctl_t [NLVL-1:0] ctl;
    pm_state_e          state;

    pmc_access u_access (
        .addr    (csr_addr),
        .mode    (cur_mode),
        .we      (csr_we),
        .selfmod (selfmod),
        .dec     (dec),
        .illegal (csr_illegal),
        .wr_ok   (wr_ok)
    );

    assign state_on     = (state != ST_OFF);
    assign cfg_wr       = wr_ok && (dec.kind == RK_CFG);
    assign bank_changed = |bchg;
    assign pm_state     = state;

    for (genvar g = 0; g < NLVL; g++) begin : g_lvl
        logic sel;
        assign sel        = wr_ok && state_on && (dec.lvl == 2'(g));
        assign selfmod[g] = ctl[g].selfmod;
        assign pm_ctl[g]  = ctl[g];

        pmc_bank #(.XLEN(XLEN), .MASK_LSB(MASK_LSB)) u_bank (
            .clk     (clk),
            .rst     (rst),
            .wr_mask (sel && (dec.kind == RK_MASK)),
            .wr_base (sel && (dec.kind == RK_BASE)),
            .wdata   (csr_wdata),
            .mask    (pm_mask[g]),
            .base    (pm_base[g]),
            .changed (bchg[g])
        );
    end

    pmc_ctl u_ctl (
        .clk          (clk),
        .rst          (rst),
        .cfg_wr       (cfg_wr),
        .cfg_lvl      (dec.lvl),
        .wdata        (csr_wdata[CFGW-1:0]),
        .bank_changed (bank_changed),
        .ctl          (ctl),
        .state        (state)
    );

    always_comb begin
        csr_rdata = '0;
        if (!csr_illegal) begin
            case (dec.kind)
                RK_CFG:  csr_rdata = XLEN'(pm_view(dec.lvl, pm_ctl, state));
                RK_MASK: csr_rdata = pm_mask[dec.lvl];
                RK_BASE: csr_rdata = pm_base[dec.lvl];
                default: csr_rdata = '0;
            endcase
        end
    end

    assert_illegal_reads_zero_R1: assert property (@(posedge clk) disable iff (rst)
        csr_illegal |-> (csr_rdata == '0));

    assert_illegal_no_change_R2: assert property (@(posedge clk) disable iff (rst)
        (csr_we && csr_illegal) |=>
            ($stable(pm_mask) && $stable(pm_base) && $stable(pm_ctl) && $stable(pm_state)));

    assert_self_gate_R6: assert property (@(posedge clk) disable iff (rst)
        (csr_we && !csr_illegal && (cur_mode == dec.lvl) && !selfmod[dec.lvl]) |=>
            ($stable(pm_mask) && $stable(pm_base) && $stable(pm_ctl) && $stable(pm_state)));

endmodule

// File: tb/pmc_regfile_tb.sv
module pmc_regfile_tb;

    localparam int XLEN = 64;

    logic                 clk = 1'b0;
    logic                 rst;
    logic [11:0]          csr_addr;
    logic [XLEN-1:0]      csr_wdata;
    logic                 csr_we;
    logic [1:0]           cur_mode;
    logic [XLEN-1:0]      csr_rdata;
    logic                 csr_illegal;
    logic [3:0][XLEN-1:0] pm_mask;
    logic [3:0][XLEN-1:0] pm_base;
    logic [3:0][2:0]      pm_ctl;
    logic [1:0]           pm_state;

    always #4 clk = ~clk;

    pmc_regfile #(.XLEN(XLEN), .MASK_LSB(48)) u_dut (
        .clk(clk), .rst(rst), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
        .csr_we(csr_we), .cur_mode(cur_mode), .csr_rdata(csr_rdata),
        .csr_illegal(csr_illegal), .pm_mask(pm_mask), .pm_base(pm_base),
        .pm_ctl(pm_ctl), .pm_state(pm_state)
    );

    typedef struct {
        logic [XLEN-1:0] rdata;
        logic            ill;
        int              chk;
        int              lvl;
        logic [XLEN-1:0] xval;
        string           tag;
    } item_t;

    item_t sbq[$];
    int    total = 0;
    int    bad   = 0;
    bit    done  = 1'b0;

    localparam logic [1:0] MU = 2'd0, MVS = 2'd1, MS = 2'd2, MM = 2'd3;
    localparam logic [XLEN-1:0] MTOP = 64'hFFFF_0000_0000_0000;

    task automatic rd(input logic [11:0] a, input logic [1:0] m, input logic [XLEN-1:0] exp,
                      input logic ill, input string tag, input int chk = 0, input int lvl = 0,
                      input logic [XLEN-1:0] xv = '0);
        item_t it;
        @(negedge clk);
        csr_addr = a; cur_mode = m; csr_we = 1'b0; csr_wdata = '0;
        it.rdata = exp; it.ill = ill; it.chk = chk; it.lvl = lvl; it.xval = xv; it.tag = tag;
        sbq.push_back(it);
    endtask

    task automatic wr(input logic [11:0] a, input logic [1:0] m, input logic [XLEN-1:0] d);
        @(negedge clk);
        csr_addr = a; cur_mode = m; csr_wdata = d; csr_we = 1'b1;
    endtask

    // Monitor: compares the item pushed at this falling edge, 2 ns later.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (sbq.size() > 0) begin
                item_t it;
                logic [XLEN-1:0] act;
                it = sbq.pop_front();
                total++;
                if (csr_illegal !== it.ill || csr_rdata !== it.rdata) begin
                    bad++;
                    $display("FAIL %s: actual rdata=%h ill=%b expected rdata=%h ill=%b",
                             it.tag, csr_rdata, csr_illegal, it.rdata, it.ill);
                end
                if (it.chk != 0) begin
                    total++;
                    case (it.chk)
                        1:       act = XLEN'(pm_state);
                        2:       act = pm_mask[it.lvl];
                        default: act = pm_base[it.lvl];
                    endcase
                    if (act !== it.xval) begin
                        bad++;
                        $display("FAIL %s export: actual=%h expected=%h", it.tag, act, it.xval);
                    end
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; csr_addr = '0; csr_wdata = '0; csr_we = 1'b0; cur_mode = MM;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // Reset values
        rd(12'h3c0, MM, 64'h401, 1'b0, "R11 R3 R5 machine view after reset", 1, 0, 64'd1);
        rd(12'h1c0, MS, 64'h001, 1'b0, "R11 supervisor view after reset");
        rd(12'h4c0, MU, 64'h000, 1'b0, "R11 user view after reset");
        rd(12'h3c1, MM, 64'h0,   1'b0, "R11 machine mask after reset");

        // Address and level legality
        rd(12'h3c3, MM, 64'h0, 1'b1, "R1 unlisted low byte");
        rd(12'h5c0, MM, 64'h0, 1'b1, "R1 unlisted page");
        rd(12'h0c0, MM, 64'h0, 1'b1, "R1 page zero");
        rd(12'h3c0, MS, 64'h0, 1'b1, "R2 supervisor reads machine control");
        rd(12'h1c1, MVS, 64'h0, 1'b1, "R2 virtual supervisor reads supervisor mask");
        rd(12'h2c1, MU, 64'h0, 1'b1, "R2 user reads virtual supervisor mask");

        // Implemented mask bits and dirty marking
        wr(12'h3c1, MM, '1);
        rd(12'h3c1, MM, MTOP, 1'b0, "R10 R12 mask low bits read zero", 2, 3, MTOP);
        rd(12'h3c0, MM, 64'h403, 1'b0, "R8 mask change sets dirty", 1, 0, 64'd3);

        // Direct state write with unchanged controls
        wr(12'h3c0, MM, 64'h402);
        rd(12'h3c0, MM, 64'h402, 1'b0, "R9 state loaded as clean", 1, 0, 64'd2);

        // Own-level write without self-manage is ignored
        wr(12'h1c2, MS, 64'h1234);
        rd(12'h1c2, MM, 64'h0, 1'b0, "R6 supervisor own write ignored");
        rd(12'h3c0, MM, 64'h402, 1'b0, "R6 state untouched by ignored write");

        // Machine grants supervisor self-manage
        wr(12'h3c0, MM, 64'h482);
        rd(12'h3c0, MM, 64'h483, 1'b0, "R8 control change sets dirty");
        wr(12'h3c0, MM, 64'h082);
        rd(12'h3c0, MM, 64'h482, 1'b0, "R5 machine self-manage stays 1");

        // Supervisor now writes its own base
        wr(12'h1c2, MS, 64'h1234);
        rd(12'h1c2, MS, 64'h1234, 1'b0, "R6 R12 self-managed base write", 3, 2, 64'h1234);
        rd(12'h1c0, MS, 64'h083, 1'b0, "R4 R8 supervisor view dirty");

        // Virtual supervisor view written by machine
        wr(12'h2c0, MM, 64'h15A);
        rd(12'h2c0, MVS, 64'h15B, 1'b0, "R4 virtual supervisor view");
        rd(12'h4c0, MU, 64'h018, 1'b0, "R4 user view holds only user control");
        rd(12'h3c0, MM, 64'h49B, 1'b0, "R3 machine view field placement");
        rd(12'h1c0, MS, 64'h09B, 1'b0, "R4 supervisor view field placement");

        // User view cannot touch state
        wr(12'h3c0, MM, 64'h49A);
        wr(12'h4c0, MU, 64'h01B);
        rd(12'h3c0, MM, 64'h49A, 1'b0, "R4 user view write leaves state", 1, 0, 64'd2);

        // Off state blocks register writes
        wr(12'h3c0, MM, 64'h498);
        rd(12'h3c0, MM, 64'h498, 1'b0, "R9 state set off", 1, 0, 64'd0);
        wr(12'h3c1, MM, 64'h0);
        rd(12'h3c1, MM, MTOP, 1'b0, "R7 mask write ignored while off");
        wr(12'h3c0, MM, 64'h4D8);
        rd(12'h3c0, MM, 64'h498, 1'b0, "R7 control write ignored while off");
        wr(12'h3c0, MM, 64'h499);
        rd(12'h3c0, MM, 64'h499, 1'b0, "R7 state writable while off", 1, 0, 64'd1);

        // Illegal write changes nothing
        wr(12'h3c1, MU, 64'h0);
        rd(12'h3c1, MM, MTOP, 1'b0, "R2 illegal write left mask", 2, 3, MTOP);
        rd(12'h3c0, MM, 64'h499, 1'b0, "R2 illegal write left state");

        @(negedge clk);
        repeat (3) @(negedge clk);
        wait (sbq.size() == 0);
        #3;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule